// File: doc/BRIEF.md
# Programmable-Length Serial Master Shifter

This block is the master half of a synchronous serial port. A host writes a byte into the shift register and picks a bit rate and a frame length in the divider register. It then sets the run bit in the mode register. The engine drives a serial clock and presents the register's top bit on the serial output. It samples the serial input once per bit and shifts the register left, so received bits enter at the low end. When the frame is done it clears the run bit and sets a sticky completion flag. That flag raises an interrupt request when the mask bit in the mode register allows it.

The bit period is the core clock divided by a fixed factor of 13 and then by a power of two. Frames may be 1 to 15 bits long over an 8-bit register. Bits beyond the eighth push earlier received bits back out of the serial output, and the register keeps only the last eight received. This lets a host skip unwanted leading bits of a stream. While a frame is running, the data and divider registers refuse writes. A separate pin-select register chooses whether the output pin carries the serial data or an ordinary level supplied from outside.

The controller is a three-state machine. The states are ST_IDLE, ST_HALF_A (first half of a bit) and ST_HALF_B (second half of a bit). The transitions are:
- ST_IDLE to ST_HALF_A on an accepted start.
- ST_HALF_A to ST_HALF_B at the end of the first half, when the input bit is sampled.
- ST_HALF_B to ST_HALF_A at the end of a bit that is not the last, when the register shifts.
- ST_HALF_B to ST_IDLE at the end of the last bit, when the register shifts, the flag is set and the run bit clears.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, the data register (address 0), the divider register (address 1) and the mode register (address 3) read 00h, irq is low, and sck equals cpol.
- R2: Each bit lasts P = 13 x ratio core cycles, where the rate code in divider bits 2:0 gives a ratio of 1, 2, 4, 8, 16, 32, 64 or 256 for codes 0 to 7. A frame of N bits clears the run bit (mode bit 0) exactly N x P clock edges after the edge that accepted the start write.
- R3: Divider bits 6:3 set the frame length N, with codes 1 to 15 giving 1 to 15 bits. A start written while this field is 0 is ignored, and the run bit stays 0.
- R4: The mosi output always equals data register bit 7, so data leaves most significant bit first and the register moves left by one at the end of each bit.
- R5: The first half of each bit lasts floor(P/2) cycles. miso is sampled at the last edge of that half and enters the register's bit 0 at the end of the bit. After N bits the register holds the original byte shifted left by N with the received bits below it, truncated to 8 bits.
- R6: sck equals cpol while idle. During a bit it equals the inverse of cpol in the first half when cpha is 1, and in the second half when cpha is 0.
- R7: At the end of the last bit, divider bit 7 (the completion flag) becomes 1 on the same edge as the run bit becomes 0.
- R8: Writing the divider register with bit 7 at 0 while idle clears the flag. Writing bit 7 at 1 leaves the flag unchanged, and software cannot set it.
- R9: irq is high exactly when the flag is 1 and mode bit 1 (the interrupt mask) is 1.
- R10: While the run bit is 1, writes to the data and divider registers, and start writes, have no effect.
- R11: Pin-select register bit 0 (address 2, write-only, reads 00h) routes mosi to sout_pin when 1. When it is 0, sout_pin follows io_level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 data, 1 divider, 2 pin select, 3 mode |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 8 | Combinational read data |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Serial clock phase select |
| miso | input | 1 | Serial data in |
| io_level | input | 1 | Level driven on sout_pin when not routed |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| sout_pin | output | 1 | Output pin after routing |
| irq | output | 1 | Interrupt request |

## Verification
A wrong state or a miscounted half-period shows up on sck within one core cycle, because sck is decoded directly from the state. A wrong bit index or a wrong sampling point leaves the run bit set for the wrong number of cycles. It also leaves the wrong byte in the data register, and mosi diverges within one bit period. A flag or lock fault is visible on the divider read and on irq on the cycle after the offending edge. For these reasons the bench compares every output and the selected read word against a behavioural model on every cycle.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_DIV  = 2'd1;
    localparam logic [1:0] REG_PIN  = 2'd2;
    localparam logic [1:0] REG_MODE = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HALF_A = 2'd1,
        ST_HALF_B = 2'd2
    } eng_state_t;

endpackage

// File: rtl/spi_eng_rate.sv
module spi_eng_rate #(
    parameter int PRESCALE = 13,
    parameter int CODE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [CODE_W-1:0] rate_code,
    output logic              half_end,
    output logic              bit_end
);
    localparam int MAX_SHIFT  = 2 ** CODE_W;
    localparam int MAX_PERIOD = PRESCALE * (2 ** MAX_SHIFT);
    localparam int CNT_W      = $clog2(MAX_PERIOD) + 1;

    logic [CODE_W:0]  shift_amt;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] cnt_q;

    // The top code skips one power of two, so it divides by 2**(code+1).
    always_comb begin
        shift_amt = {1'b0, rate_code} + {{CODE_W{1'b0}}, &rate_code};
        period    = CNT_W'(PRESCALE) << shift_amt;
        half      = period >> 1;
        half_end  = active && (cnt_q == half - 1'b1);
        bit_end   = active && (cnt_q == period - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active || bit_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < period));

endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    input  logic              frame_start,
    input  logic              capture_en,
    input  logic              miso,
    input  logic              shift_en,
    input  logic [LEN_W-1:0]  frame_len,
    output logic [DATA_W-1:0] data_q,
    output logic              last_bit
);
    logic             rx_q;
    logic [LEN_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            rx_q   <= 1'b0;
            idx_q  <= '0;
        end else begin
            if (load_en) begin
                data_q <= load_val;
            end else if (shift_en) begin
                data_q <= {data_q[DATA_W-2:0], rx_q};
            end
            if (capture_en) begin
                rx_q <= miso;
            end
            if (frame_start) begin
                idx_q <= '0;
            end else if (shift_en) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign last_bit = (idx_q == frame_len - 1'b1);

    assert_idx_below_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> (idx_q < frame_len));

    assert_no_load_while_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_en && shift_en));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int LEN_W    = 4,
    parameter int CODE_W   = 3,
    parameter int PRESCALE = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              miso,
    input  logic              io_level,
    output logic              sck,
    output logic              mosi,
    output logic              sout_pin,
    output logic              irq
);
    localparam int LEN_LO  = CODE_W;
    localparam int LEN_HI  = CODE_W + LEN_W - 1;
    localparam int FLAG_B  = CODE_W + LEN_W;

    eng_state_t state_q, state_d;

    logic [CODE_W-1:0] rate_q;
    logic [LEN_W-1:0]  len_q;
    logic              flag_q, mask_q, route_q;
    logic              idle, start, load_en;
    logic              wr_div, wr_pin, wr_mode;
    logic              half_end, bit_end, last_bit;
    logic              capture_en, shift_en, done;
    logic [DATA_W-1:0] data_q;

    assign idle    = (state_q == ST_IDLE);
    assign load_en = wr_en && (wr_addr == REG_DATA) && idle;
    assign wr_div  = wr_en && (wr_addr == REG_DIV) && idle;
    assign wr_pin  = wr_en && (wr_addr == REG_PIN);
    assign wr_mode = wr_en && (wr_addr == REG_MODE);
    assign start   = wr_mode && wr_data[0] && idle && (len_q != '0);

    spi_eng_rate #(.PRESCALE(PRESCALE), .CODE_W(CODE_W)) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (!idle),
        .rate_code (rate_q),
        .half_end  (half_end),
        .bit_end   (bit_end)
    );

    spi_eng_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (load_en),
        .load_val    (wr_data),
        .frame_start (start),
        .capture_en  (capture_en),
        .miso        (miso),
        .shift_en    (shift_en),
        .frame_len   (len_q),
        .data_q      (data_q),
        .last_bit    (last_bit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)    state_d = ST_HALF_A;
            ST_HALF_A: if (half_end) state_d = ST_HALF_B;
            ST_HALF_B: if (bit_end)  state_d = last_bit ? ST_IDLE : ST_HALF_A;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        capture_en = (state_q == ST_HALF_A) && half_end;
        shift_en   = (state_q == ST_HALF_B) && bit_end;
        done       = shift_en && last_bit;
        sck        = cpol ^ (cpha ? (state_q == ST_HALF_A) : (state_q == ST_HALF_B));
        mosi       = data_q[DATA_W-1];
        sout_pin   = route_q ? mosi : io_level;
        irq        = flag_q && mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q  <= '0;
            len_q   <= '0;
            flag_q  <= 1'b0;
            mask_q  <= 1'b0;
            route_q <= 1'b0;
        end else begin
            if (wr_div) begin
                rate_q <= wr_data[CODE_W-1:0];
                len_q  <= wr_data[LEN_HI:LEN_LO];
            end
            if (done) begin
                flag_q <= 1'b1;
            end else if (wr_div && !wr_data[FLAG_B]) begin
                flag_q <= 1'b0;
            end
            if (wr_mode) begin
                mask_q <= wr_data[1];
            end
            if (wr_pin) begin
                route_q <= wr_data[0];
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            REG_DATA: rd_data = data_q;
            REG_DIV:  rd_data = DATA_W'({flag_q, len_q, rate_q});
            REG_MODE: rd_data = DATA_W'({mask_q, !idle});
            default:  rd_data = '0;
        endcase
    end

    assert_flag_on_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle ##1 idle) |-> flag_q);

    assert_flag_only_from_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(state_q == ST_HALF_B));

    assert_div_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && $past(!idle)) |-> ($stable(rate_q) && $stable(len_q)));

    assert_start_needs_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle ##1 !idle) |-> (len_q != '0));

endmodule

// File: tb/tb_spi_shift_engine.sv
module tb_spi_shift_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       cpol = 1'b0, cpha = 1'b0, miso = 1'b0, io_level = 1'b0;
    logic       sck, mosi, sout_pin, irq;

    always #4 clk = ~clk;

    spi_shift_engine dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cpol(cpol), .cpha(cpha), .miso(miso),
        .io_level(io_level), .sck(sck), .mosi(mosi), .sout_pin(sout_pin), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Behavioural reference: phase 0 idle, 1 first half, 2 second half
    int         m_ph = 0, m_c = 0, m_bit = 0;
    logic [7:0] m_data = 8'h00;
    logic       m_rx = 1'b0;
    logic [3:0] m_len = 4'd0;
    logic [2:0] m_cd = 3'd0;
    logic       m_flag = 1'b0, m_mask = 1'b0, m_sel = 1'b0, m_run = 1'b0;

    function automatic int period_of(input logic [2:0] cd);
        int r;
        r = (cd == 3'd7) ? 256 : (1 << cd);
        return 13 * r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_c = 0; m_bit = 0; m_data = 8'h00; m_rx = 1'b0;
            m_len = 4'd0; m_cd = 3'd0; m_flag = 1'b0; m_mask = 1'b0;
            m_sel = 1'b0; m_run = 1'b0;
        end else begin
            int  p;
            int  h;
            bit  busy;
            p = period_of(m_cd);
            h = p / 2;
            busy = (m_ph != 0);
            if (m_ph == 1) begin
                if (m_c == h - 1) begin
                    m_rx = miso;
                    m_ph = 2;
                end
                m_c++;
            end else if (m_ph == 2) begin
                if (m_c == p - 1) begin
                    m_data = {m_data[6:0], m_rx};
                    m_c = 0;
                    if (m_bit == int'(m_len) - 1) begin
                        m_ph = 0; m_flag = 1'b1; m_run = 1'b0;
                    end else begin
                        m_bit++;
                        m_ph = 1;
                    end
                end else begin
                    m_c++;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: if (!busy) m_data = wr_data;
                    2'd1: if (!busy) begin
                        m_cd = wr_data[2:0];
                        m_len = wr_data[6:3];
                        if (!wr_data[7]) m_flag = 1'b0;
                    end
                    2'd2: m_sel = wr_data[0];
                    default: begin
                        m_mask = wr_data[1];
                        if (wr_data[0] && !busy && m_len != 4'd0) begin
                            m_run = 1'b1; m_ph = 1; m_c = 0; m_bit = 0;
                        end
                    end
                endcase
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic       e_sck;
            logic [7:0] e_rd;
            e_sck = cpol ^ ((m_ph == 1) ? cpha : (m_ph == 2) ? !cpha : 1'b0);
            check("R6 sck", {7'd0, sck}, {7'd0, e_sck});
            check("R4 mosi", {7'd0, mosi}, {7'd0, m_data[7]});
            check("R11 sout_pin", {7'd0, sout_pin}, {7'd0, m_sel ? m_data[7] : io_level});
            check("R9 irq", {7'd0, irq}, {7'd0, m_flag & m_mask});
            case (rd_addr)
                2'd0: e_rd = m_data;
                2'd1: e_rd = {m_flag, m_len, m_cd};
                2'd2: e_rd = 8'h00;
                default: e_rd = {6'd0, m_mask, m_run};
            endcase
            case (rd_addr)
                2'd0: check("R5 data read", rd_data, e_rd);
                2'd1: check("R7 divider read", rd_data, e_rd);
                2'd2: check("R11 pin read", rd_data, e_rd);
                default: check("R2 mode read", rd_data, e_rd);
            endcase
        end
    end

    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        #1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso <= lfsr[0];
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); #1;
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_idle(output int cyc);
        rd_addr = 2'd3;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (rd_data[0] === 1'b1 && cyc < 60000);
    endtask

    task automatic frame(input logic [2:0] cd, input logic [3:0] len, input logic [7:0] d,
                         input logic pol, input logic pha, input logic msk);
        int         cyc;
        logic [7:0] v;
        @(negedge clk); #1;
        cpol = pol; cpha = pha;
        wr(2'd1, {1'b0, len, cd});
        wr(2'd0, d);
        check("R4 msb first", {7'd0, mosi}, {7'd0, d[7]});
        wr(2'd3, {6'd0, msk, 1'b1});
        wait_idle(cyc);
        check("R2 frame length in cycles", 8'(cyc / 13), 8'(int'(len) * period_of(cd) / 13));
        check("R2 cycles exact", {7'd0, cyc == int'(len) * period_of(cd)}, 8'd1);
        rd(2'd1, v);
        check("R7 flag after frame", {7'd0, v[7]}, 8'd1);
        check("R9 irq after frame", {7'd0, irq}, {7'd0, msk});
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int         cyc;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        rd(2'd0, v); check("R1 data reset", v, 8'h00);
        rd(2'd1, v); check("R1 divider reset", v, 8'h00);
        rd(2'd3, v); check("R1 mode reset", v, 8'h00);
        check("R1 irq reset", {7'd0, irq}, 8'd0);
        check("R1 sck idle", {7'd0, sck}, {7'd0, cpol});

        // Zero length: start ignored
        wr(2'd3, 8'h01);
        rd(2'd3, v); check("R3 zero length no start", {7'd0, v[0]}, 8'd0);

        frame(3'd0, 4'd8, 8'hA5, 1'b0, 1'b0, 1'b1);
        frame(3'd2, 4'd3, 8'h3C, 1'b1, 1'b1, 1'b1);
        frame(3'd1, 4'd12, 8'hC3, 1'b0, 1'b1, 1'b0);
        frame(3'd0, 4'd15, 8'hFF, 1'b1, 1'b0, 1'b1);
        frame(3'd3, 4'd5, 8'h5A, 1'b0, 1'b0, 1'b1);
        frame(3'd7, 4'd1, 8'h80, 1'b0, 1'b1, 1'b1);

        // Flag: writing 1 keeps it, writing 0 clears it
        wr(2'd1, 8'hA1);
        rd(2'd1, v); check("R8 write one keeps flag", v, 8'hA1);
        wr(2'd1, 8'h21);
        rd(2'd1, v); check("R8 write zero clears flag", v, 8'h21);
        wr(2'd1, 8'h80 | 8'h21);
        rd(2'd1, v); check("R8 software cannot set flag", v, 8'h21);

        // Mask off: flag set yet irq stays low
        frame(3'd0, 4'd2, 8'h0F, 1'b0, 1'b0, 1'b0);
        check("R9 masked irq", {7'd0, irq}, 8'd0);
        wr(2'd3, 8'h02);
        check("R9 unmasked irq", {7'd0, irq}, 8'd1);

        // Lock while running
        wr(2'd1, 8'h21);
        wr(2'd0, 8'h96);
        wr(2'd3, 8'h03);
        wr(2'd1, 8'h7F);
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h03);
        rd(2'd1, v); check("R10 divider locked", v, 8'h21);
        wait_idle(cyc);
        rd(2'd1, v); check("R10 divider after frame", v, 8'hA1);

        // Output pin routing
        @(negedge clk); #1 io_level = 1'b1;
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h00);
        check("R11 pin follows io_level", {7'd0, sout_pin}, 8'd1);
        wr(2'd2, 8'h01);
        check("R11 pin follows mosi", {7'd0, sout_pin}, 8'd0);
        rd(2'd2, v); check("R11 pin register reads zero", v, 8'h00);

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule